// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block is a per-core data cache that stays coherent with its peers by watching a shared bus. It is direct-mapped, write-back and write-allocate, and each line holds a single data word. Every line carries a tag, a data word and a two-bit coherence state (Invalid, Shared, Exclusive, Modified). Core reads and writes that hit in a suitable state finish without any bus traffic. Misses, upgrades and dirty evictions go through a simple request/grant bus.

The bus carries four commands: a plain read, a read that intends to modify (RWITM), an invalidate, and a write-back. Every transaction the cache places on the bus is seen by the other caches on their snoop ports. A snooping cache answers within the same cycle with three indications: a hit flag, which the requester uses to pick Shared or Exclusive on a read fill; a dirty flag, which tells the bus to copy the supplied word into memory; and a retry flag. A cache that holds a line Modified and sees an RWITM for it blocks that request, hands its word to memory and invalidates its copy. The requester then issues the RWITM again, and the second attempt completes as the case where no other cache holds a copy. A probe port exposes the tag and state of a chosen line so that coherence across caches can be observed.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid (state code 2'b00), core_ready is 1 and bus_req is 0; bus_req is never high while core_ready is high.
- R2: A core read that hits a line in Shared, Exclusive or Modified state returns the stored word with a one-cycle core_ack pulse, issues no bus transaction and leaves the state unchanged.
- R3: A read miss that no other cache answers issues a read (bus_cmd 2'b00), installs the memory word and sets the line to Exclusive (2'b10).
- R4: A read miss that another cache answers in Exclusive or Shared takes the word from that cache, and both copies end in Shared (2'b01).
- R5: A read miss that hits a Modified (2'b11) line in another cache takes the word from that cache, which raises snp_dirty so that memory is updated; both copies end in Shared.
- R6: A write hit in Exclusive sets the line to Modified and a write hit in Modified keeps it Modified; neither issues a bus transaction.
- R7: A write hit in Shared issues an invalidate (bus_cmd 2'b10) and then sets the line to Modified; a snooping cache holding the line in Shared moves it to Invalid.
- R8: A write miss issues RWITM (bus_cmd 2'b01) and installs the written word as Modified; a snooping cache holding the line in Exclusive or Shared moves it to Invalid.
- R9: A cache holding a line Modified that snoops an RWITM for it raises snp_retry and snp_dirty with its word and goes to Invalid; the requester reissues the same RWITM in the next cycle and completes with Modified.
- R10: A miss whose victim line is Modified first issues a write-back (bus_cmd 2'b11) carrying the victim's address and word, then the fill; a victim in Exclusive or Shared is replaced with no write-back.
- R11: Snooped traffic changes only a line whose index and tag both match the bus address; a line at the same index with a different tag is left unchanged.
- R12: Across caches, no address is held in Modified or Exclusive by one cache while another cache holds it in any valid state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | One-cycle core request, accepted while core_ready is 1 |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Core word address (low bits are the index, high bits the tag) |
| core_wdata | input | DATA_W | Core write data |
| core_ready | output | 1 | Controller idle and able to accept a request |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Read word (the written word for writes), valid with core_ack |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transaction completes in the granted cycle |
| bus_cmd | output | 2 | 00 read, 01 RWITM, 10 invalidate, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rdata | input | DATA_W | Fill word from a peer or from memory |
| bus_shared | input | 1 | A peer holds the line |
| bus_retry | input | 1 | A peer blocked the request |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 2 | Peer command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Peer address |
| snp_hit | output | 1 | This cache holds the snooped line |
| snp_dirty | output | 1 | This cache supplies a Modified word to be copied to memory |
| snp_retry | output | 1 | This cache blocks the peer's RWITM |
| snp_data | output | DATA_W | Word supplied to the bus |
| probe_idx | input | log2(LINES) | Line index to observe |
| probe_state | output | 2 | State of the observed line |
| probe_tag | output | ADDR_W-log2(LINES) | Tag of the observed line |

## Verification
A wrong line state shows up at the ports on the next access to that line. A line left Exclusive when it should be Shared skips the invalidate on a later write and leaves a peer holding a stale copy. The peer then returns a wrong read word. A missing transition to Invalid on a snoop raises snp_hit for a line that should be gone, which changes the peer's fill state within the same bus cycle. A lost dirty state shows up as a missing write-back and a stale memory word on the next fill. The bench follows each operation with a probe sweep across both caches and counts the granted bus cycles, so a bad state or an extra transaction is reported at the end of that operation.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} line_state_e;
  typedef enum logic [1:0] {CMD_RD = 2'b00, CMD_RWITM = 2'b01, CMD_INV = 2'b10, CMD_WB = 2'b11} bus_cmd_e;

  // State of a matching line after a peer's transaction.
  function automatic line_state_e snoop_next(line_state_e s, bus_cmd_e c);
    case (c)
      CMD_RD:    return (s == ST_I) ? ST_I : ST_S;
      CMD_RWITM: return ST_I;
      CMD_INV:   return ST_I;
      default:   return s;
    endcase
  endfunction

  // State installed by a completed fill.
  function automatic line_state_e fill_state(logic is_write, logic peer_has);
    if (is_write) return ST_M;
    return peer_has ? ST_S : ST_E;
  endfunction
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_state_e       a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_state_e       b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic [IDX_W-1:0]  c_idx,
  output line_state_e       c_st,
  output logic [TAG_W-1:0]  c_tag,
  input  logic              loc_we,
  input  logic [IDX_W-1:0]  loc_idx,
  input  line_state_e       loc_st,
  input  logic [TAG_W-1:0]  loc_tag,
  input  logic [DATA_W-1:0] loc_data,
  input  logic              snp_we,
  input  logic [IDX_W-1:0]  snp_idx,
  input  line_state_e       snp_st
);
  line_state_e       st_w   [LINES];
  logic [TAG_W-1:0]  tag_w  [LINES];
  logic [DATA_W-1:0] data_w [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_state_e       st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q   <= ST_I;
        tag_q  <= '0;
        data_q <= '0;
      end else if (loc_we && loc_idx == IDX_W'(g)) begin
        st_q   <= loc_st;
        tag_q  <= loc_tag;
        data_q <= loc_data;
      end else if (snp_we && snp_idx == IDX_W'(g)) begin
        st_q   <= snp_st;
      end
    end
    assign st_w[g]   = st_q;
    assign tag_w[g]  = tag_q;
    assign data_w[g] = data_q;
  end

  assign a_st   = st_w[a_idx];
  assign a_tag  = tag_w[a_idx];
  assign a_data = data_w[a_idx];
  assign b_st   = st_w[b_idx];
  assign b_tag  = tag_w[b_idx];
  assign b_data = data_w[b_idx];
  assign c_st   = st_w[c_idx];
  assign c_tag  = tag_w[c_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_state_e       line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_match,
  output logic              snp_hit,
  output logic              snp_dirty,
  output logic              snp_retry,
  output logic [DATA_W-1:0] snp_data,
  output logic              upd_en,
  output line_state_e       upd_st
);
  logic wants_data;

  assign snp_match  = snp_valid && line_st != ST_I && line_tag == snp_tag;
  assign wants_data = snp_cmd == CMD_RD || snp_cmd == CMD_RWITM;
  assign snp_hit    = snp_match && snp_cmd != CMD_WB;
  assign snp_dirty  = snp_match && wants_data && line_st == ST_M;
  assign snp_retry  = snp_match && snp_cmd == CMD_RWITM && line_st == ST_M;
  assign snp_data   = line_data;
  assign upd_st     = snoop_next(line_st, snp_cmd);
  assign upd_en     = snp_match && upd_st != line_st;
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_ack,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              bus_retry,
  input  logic              snp_busy,
  output logic [IDX_W-1:0]  line_idx,
  input  line_state_e       line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              loc_we,
  output line_state_e       loc_st,
  output logic [TAG_W-1:0]  loc_tag,
  output logic [DATA_W-1:0] loc_data,
  output logic              ev_read_hit,
  output logic              ev_write_own,
  output logic              ev_write_shared,
  output logic              ev_evict_dirty
);
  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_EVICT, F_FILL, F_UPG} fsm_e;

  fsm_e              state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              tag_hit, look_go, fill_ok, upg_ok, evict_ok;

  assign line_idx   = addr_q[IDX_W-1:0];
  assign tag_hit    = line_st != ST_I && line_tag == addr_q[ADDR_W-1:IDX_W];
  assign look_go    = state_q == F_LOOK && !snp_busy;

  assign ev_read_hit     = look_go && tag_hit && !we_q;
  assign ev_write_own    = look_go && tag_hit && we_q && (line_st == ST_M || line_st == ST_E);
  assign ev_write_shared = look_go && tag_hit && we_q && line_st == ST_S;
  assign ev_evict_dirty  = look_go && !tag_hit && line_st == ST_M;

  assign fill_ok  = state_q == F_FILL && bus_gnt && !bus_retry;
  assign upg_ok   = state_q == F_UPG && bus_gnt;
  assign evict_ok = state_q == F_EVICT && bus_gnt;

  always_comb begin
    bus_req  = 1'b0;
    bus_cmd  = CMD_RD;
    bus_addr = addr_q;
    case (state_q)
      F_EVICT: if (line_st == ST_M) begin
        bus_req  = 1'b1;
        bus_cmd  = CMD_WB;
        bus_addr = {line_tag, line_idx};
      end
      F_FILL: begin
        bus_req = 1'b1;
        bus_cmd = we_q ? CMD_RWITM : CMD_RD;
      end
      F_UPG: if (tag_hit && line_st == ST_S) begin
        bus_req = 1'b1;
        bus_cmd = CMD_INV;
      end
      default: ;
    endcase
  end
  assign bus_wdata = line_data;

  always_comb begin
    loc_we   = 1'b0;
    loc_st   = ST_M;
    loc_tag  = line_tag;
    loc_data = wdata_q;
    if (ev_write_own || upg_ok) begin
      loc_we = 1'b1;
    end else if (evict_ok) begin
      loc_we   = 1'b1;
      loc_st   = ST_I;
      loc_data = line_data;
    end else if (fill_ok) begin
      loc_we   = 1'b1;
      loc_st   = fill_state(we_q, bus_shared);
      loc_tag  = addr_q[ADDR_W-1:IDX_W];
      loc_data = we_q ? wdata_q : bus_rdata;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      F_IDLE:  if (core_req) state_d = F_LOOK;
      F_LOOK:  if (look_go) begin
        if (ev_read_hit || ev_write_own) state_d = F_IDLE;
        else if (ev_write_shared)        state_d = F_UPG;
        else if (ev_evict_dirty)         state_d = F_EVICT;
        else                             state_d = F_FILL;
      end
      F_EVICT: if (line_st != ST_M || bus_gnt) state_d = F_FILL;
      F_FILL:  if (fill_ok) state_d = F_IDLE;
      F_UPG:   if (!(tag_hit && line_st == ST_S)) state_d = F_FILL;
               else if (bus_gnt) state_d = F_IDLE;
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= F_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ev_read_hit || ev_write_own || fill_ok || upg_ok;
      if (state_q == F_IDLE && core_req) begin
        we_q    <= core_we;
        addr_q  <= core_addr;
        wdata_q <= core_wdata;
      end
      if (ev_read_hit)                       rdata_q <= line_data;
      else if (ev_write_own || upg_ok)       rdata_q <= wdata_q;
      else if (fill_ok)                      rdata_q <= we_q ? wdata_q : bus_rdata;
    end
  end

  assign core_ready = state_q == F_IDLE;
  assign core_ack   = ack_q;
  assign core_rdata = rdata_q;
endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_ack,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              bus_retry,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_dirty,
  output logic              snp_retry,
  output logic [DATA_W-1:0] snp_data,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic [1:0]        probe_state,
  output logic [TAG_W-1:0]  probe_tag
);
  logic [IDX_W-1:0]  line_idx;
  line_state_e       line_st, sline_st, pline_st, loc_st, upd_st;
  logic [TAG_W-1:0]  line_tag, sline_tag, loc_tag;
  logic [DATA_W-1:0] line_data, sline_data, loc_data;
  logic              loc_we, upd_en, snp_match;
  bus_cmd_e          bus_cmd_e_w;
  logic              ev_read_hit, ev_write_own, ev_write_shared, ev_evict_dirty;

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(line_idx), .a_st(line_st), .a_tag(line_tag), .a_data(line_data),
    .b_idx(snp_addr[IDX_W-1:0]), .b_st(sline_st), .b_tag(sline_tag), .b_data(sline_data),
    .c_idx(probe_idx), .c_st(pline_st), .c_tag(probe_tag),
    .loc_we(loc_we), .loc_idx(line_idx), .loc_st(loc_st), .loc_tag(loc_tag), .loc_data(loc_data),
    .snp_we(upd_en), .snp_idx(snp_addr[IDX_W-1:0]), .snp_st(upd_st)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_st(sline_st), .line_tag(sline_tag), .line_data(sline_data),
    .snp_match(snp_match), .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_retry(snp_retry),
    .snp_data(snp_data), .upd_en(upd_en), .upd_st(upd_st)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_ready(core_ready), .core_ack(core_ack), .core_rdata(core_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd_e_w), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared(bus_shared), .bus_retry(bus_retry),
    .snp_busy(snp_valid),
    .line_idx(line_idx), .line_st(line_st), .line_tag(line_tag), .line_data(line_data),
    .loc_we(loc_we), .loc_st(loc_st), .loc_tag(loc_tag), .loc_data(loc_data),
    .ev_read_hit(ev_read_hit), .ev_write_own(ev_write_own),
    .ev_write_shared(ev_write_shared), .ev_evict_dirty(ev_evict_dirty)
  );

  assign bus_cmd     = bus_cmd_e_w;
  assign probe_state = pline_st;
endmodule

// File: rtl/mesi_cache_checker.sv
module mesi_cache_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_ready,
  input logic              core_ack,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_retry,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_retry,
  input logic              snp_dirty,
  input logic              ev_read_hit,
  input logic              ev_write_own,
  input logic              ev_write_shared,
  input logic              ev_evict_dirty
);
  assert_no_req_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !core_ready);

  assert_read_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read_hit |=> (core_ack && !bus_req));

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> !core_ack);

  assert_write_own_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_own |=> (core_ack && !bus_req));

  assert_shared_write_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write_shared |=> (bus_req && bus_cmd == 2'b10));

  assert_retry_only_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> snp_dirty);

  assert_retry_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_retry) |=> (bus_req && bus_cmd == $past(bus_cmd) && bus_addr == $past(bus_addr)));

  assert_dirty_victim_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict_dirty |=> (bus_req && bus_cmd == 2'b11));
endmodule

bind mesi_snoop_cache mesi_cache_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .core_ack(core_ack),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_retry(bus_retry), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .snp_retry(snp_retry), .snp_dirty(snp_dirty),
  .ev_read_hit(ev_read_hit), .ev_write_own(ev_write_own),
  .ev_write_shared(ev_write_shared), .ev_evict_dirty(ev_evict_dirty)
);

// File: tb/tb_mesi_snoop_cache.sv
module tb_mesi_snoop_cache;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NL = 4;
  localparam int IW = 2;
  localparam int TW = AW - IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req   [2];
  logic          we    [2];
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wdat  [2];
  logic          rdy   [2];
  logic          ack   [2];
  logic [DW-1:0] rdat  [2];
  logic          breq  [2];
  logic          gnt   [2];
  logic [1:0]    cmd   [2];
  logic [AW-1:0] baddr [2];
  logic [DW-1:0] bwd   [2];
  logic [DW-1:0] brd   [2];
  logic          bsh   [2];
  logic          brt   [2];
  logic          shit  [2];
  logic          sdirty[2];
  logic          sretry[2];
  logic [DW-1:0] sdata [2];
  logic [IW-1:0] pidx  [2];
  logic [1:0]    pst   [2];
  logic [TW-1:0] ptag  [2];
  logic [DW-1:0] mem   [64];

  // Behavioural bus: cache 0 has fixed priority; the granted command is snooped by the peer.
  assign gnt[0] = breq[0];
  assign gnt[1] = breq[1] && !breq[0];

  for (genvar c = 0; c < 2; c++) begin : g_c
    localparam int P = 1 - c;
    assign brd[c] = (shit[P] && cmd[c] != 2'b10) ? sdata[P] : mem[baddr[c]];
    assign bsh[c] = shit[P];
    assign brt[c] = sretry[P];
    mesi_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) dut (
      .clk(clk), .rst_n(rst_n),
      .core_req(req[c]), .core_we(we[c]), .core_addr(addr[c]), .core_wdata(wdat[c]),
      .core_ready(rdy[c]), .core_ack(ack[c]), .core_rdata(rdat[c]),
      .bus_req(breq[c]), .bus_gnt(gnt[c]), .bus_cmd(cmd[c]), .bus_addr(baddr[c]),
      .bus_wdata(bwd[c]), .bus_rdata(brd[c]), .bus_shared(bsh[c]), .bus_retry(brt[c]),
      .snp_valid(gnt[P]), .snp_cmd(cmd[P]), .snp_addr(baddr[P]),
      .snp_hit(shit[c]), .snp_dirty(sdirty[c]), .snp_retry(sretry[c]), .snp_data(sdata[c]),
      .probe_idx(pidx[c]), .probe_state(pst[c]), .probe_tag(ptag[c])
    );
  end

  always @(posedge clk) begin
    if (gnt[0] && cmd[0] == 2'b11) mem[baddr[0]] <= bwd[0];
    if (gnt[1] && cmd[1] == 2'b11) mem[baddr[1]] <= bwd[1];
    if (gnt[0] && sdirty[1]) mem[baddr[0]] <= sdata[1];
    if (gnt[1] && sdirty[0]) mem[baddr[1]] <= sdata[0];
  end

  int checks = 0;
  int errors = 0;
  int txns   = 0;
  bit done   = 0;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && (gnt[0] || gnt[1])) txns++;

  // Scoreboard: expected core results per cache.
  logic [DW-1:0] exp_q0[$], exp_q1[$];
  string         rq_q0[$],  rq_q1[$];
  always @(negedge clk) begin
    if (rst_n && ack[0]) begin
      if (exp_q0.size() == 0) chk("scoreboard c0", 32'(rdat[0]), 32'hDEAD);
      else chk(rq_q0.pop_front(), 32'(rdat[0]), 32'(exp_q0.pop_front()));
    end
    if (rst_n && ack[1]) begin
      if (exp_q1.size() == 0) chk("scoreboard c1", 32'(rdat[1]), 32'hDEAD);
      else chk(rq_q1.pop_front(), 32'(rdat[1]), 32'(exp_q1.pop_front()));
    end
  end

  task automatic op(int c, bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] e,
                    string rq, int exp_txn);
    int t0;
    if (c == 0) begin exp_q0.push_back(e); rq_q0.push_back(rq); end
    else        begin exp_q1.push_back(e); rq_q1.push_back(rq); end
    @(negedge clk);
    while (!rdy[c]) @(negedge clk);
    t0 = txns;
    req[c] = 1'b1; we[c] = w; addr[c] = a; wdat[c] = d;
    @(negedge clk);
    req[c] = 1'b0;
    while (!ack[c]) @(negedge clk);
    chk({rq, " bus transactions"}, 32'(txns - t0), 32'(exp_txn));
  endtask

  task automatic probe(int c, int idx, logic [1:0] es, logic [TW-1:0] et, string rq);
    pidx[c] = IW'(idx);
    #1;
    chk({rq, " state"}, 32'(pst[c]), 32'(es));
    if (es != 2'b00) chk({rq, " tag"}, 32'(ptag[c]), 32'(et));
  endtask

  // R12: no M/E line coexists with another valid copy of the same address.
  task automatic coherence();
    bit bad = 0;
    for (int i = 0; i < NL; i++) begin
      pidx[0] = IW'(i); pidx[1] = IW'(i);
      #1;
      if (pst[0] != 2'b00 && pst[1] != 2'b00 && ptag[0] == ptag[1] &&
          (pst[0][1] || pst[1][1])) bad = 1;
    end
    chk("R12 coherence", 32'(bad), 32'd0);
  endtask

  localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + 16'(i);
    for (int c = 0; c < 2; c++) begin
      req[c] = 0; we[c] = 0; addr[c] = '0; wdat[c] = '0; pidx[c] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < NL; i++) begin
      probe(0, i, SI, '0, "R1 c0");
      probe(1, i, SI, '0, "R1 c1");
    end
    chk("R1 ready", 32'(rdy[0] && rdy[1]), 32'd1);
    chk("R1 no req", 32'(breq[0] || breq[1]), 32'd0);

    // R3 read miss, no peer copy -> E
    op(0, 0, 6'h04, '0, 16'h1004, "R3 fill", 1);
    probe(0, 0, SE, 4'h1, "R3 c0");
    // R2 read hit in E
    op(0, 0, 6'h04, '0, 16'h1004, "R2 hit E", 0);
    probe(0, 0, SE, 4'h1, "R2 c0");
    // R6 write hits E then M
    op(0, 1, 6'h04, 16'hAAA1, 16'hAAA1, "R6 E write", 0);
    probe(0, 0, SM, 4'h1, "R6 c0");
    op(0, 1, 6'h04, 16'hAAA2, 16'hAAA2, "R6 M write", 0);
    op(0, 0, 6'h04, '0, 16'hAAA2, "R2 hit M", 0);
    // R5 peer M supplies, memory copied, both S
    op(1, 0, 6'h04, '0, 16'hAAA2, "R5 read", 1);
    probe(0, 0, SS, 4'h1, "R5 c0");
    probe(1, 0, SS, 4'h1, "R5 c1");
    chk("R5 memory", 32'(mem[4]), 32'hAAA2);
    coherence();
    // R7 write hit in S -> invalidate, peer I
    op(1, 1, 6'h04, 16'hBBB1, 16'hBBB1, "R7 upgrade", 1);
    probe(1, 0, SM, 4'h1, "R7 c1");
    probe(0, 0, SI, 4'h1, "R7 c0");
    coherence();
    // R9 RWITM blocked by M owner, retried
    op(0, 1, 6'h04, 16'hCCC1, 16'hCCC1, "R9 rwitm", 2);
    probe(0, 0, SM, 4'h1, "R9 c0");
    probe(1, 0, SI, 4'h1, "R9 c1");
    chk("R9 memory", 32'(mem[4]), 32'hBBB1);
    coherence();
    // R10 dirty eviction + R4 peer E supplies
    op(1, 0, 6'h08, '0, 16'h1008, "R3 fill c1", 1);
    op(0, 0, 6'h08, '0, 16'h1008, "R10 R4 read", 2);
    chk("R10 memory", 32'(mem[4]), 32'hCCC1);
    probe(0, 0, SS, 4'h2, "R4 c0");
    probe(1, 0, SS, 4'h2, "R4 c1");
    op(1, 0, 6'h08, '0, 16'h1008, "R2 hit S", 0);
    coherence();
    // R10 silent S eviction + R11 same index, different tag untouched
    op(0, 1, 6'h0C, 16'hDDD1, 16'hDDD1, "R10 R11 write miss", 1);
    probe(0, 0, SM, 4'h3, "R11 c0");
    probe(1, 0, SS, 4'h2, "R11 c1");
    chk("R10 memory untouched", 32'(mem[8]), 32'h1008);
    coherence();
    // R8 write miss with peer E
    op(1, 0, 6'h11, '0, 16'h1011, "R3 fill c1 idx1", 1);
    op(0, 1, 6'h11, 16'hEEE1, 16'hEEE1, "R8 rwitm", 1);
    probe(0, 1, SM, 4'h4, "R8 c0");
    probe(1, 1, SI, 4'h4, "R8 c1");
    coherence();
    // R5 again at another index; R4 from S via c0 then
    op(1, 0, 6'h11, '0, 16'hEEE1, "R5 read idx1", 1);
    chk("R5 memory idx1", 32'(mem[17]), 32'hEEE1);
    probe(0, 1, SS, 4'h4, "R5 c0 idx1");
    op(0, 0, 6'h11, '0, 16'hEEE1, "R2 hit S c0", 0);
    coherence();

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q0.size() + exp_q1.size()), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule